// File: doc/BRIEF.md
# Path-History Indirect Target Predictor

This block predicts the destination of indirect branches from a small direct-mapped target cache. The cache is looked up not by the branch address alone but by a hash of that address and a 15-bit path register. The path register holds a compressed record of the last few taken branches, so the same indirect branch reached along different paths can keep different targets in different entries.

The path register moves forward on the retire stream. Each relevant retired branch shifts it two places left, dropping the top bits, and then XORs in a 15-bit contribution. Taken conditional branches feed their own address. Indirect branches feed part of their address together with the low bits of their target. Every other branch leaves the path alone.

Lookups combine the fetch address, the current path value and a qualifier that says the main target buffer also hit. The hit flag and the predicted target come out in the same cycle. A separate write port installs a resolved target at the hashed entry and overwrites whatever lived there. The write uses the path value as it stood before any retire in the same cycle.

Top module: `itp_predictor`

Address ports carry address bits 18 down to 4 only, called the line field. Line bit k is address bit k+4.

## Requirements
- R1: After reset the path register is zero and every entry is invalid, so no lookup hits until a write has been made.
- R2: A retired branch of kind 0 (conditional) with taken=1 sets the path to ((path << 2) mod 2^15) XOR line, where line is address bits [18:4].
- R3: A retired branch of kind 1 (indirect) sets the path to ((path << 2) mod 2^15) XOR {address bits [18:12], target bits [5:0]}, whatever the taken flag.
- R4: Some retires leave the path unchanged. These are a conditional branch with taken=0, kind 2 (direct jump), kind 3 (call), kind 4 (return) and kinds 5 to 7.
- R5: The 15-bit hash h is built as follows. h[14] = addr[12] XOR path[14]. h[13:6] = addr[11:4] XOR path[13:6]. h[5:0] = addr[18:13] XOR path[5:0].
- R6: The table is direct mapped with 256 entries. The index is h[13:6] and the 7-bit tag is {h[14], h[5:0]}. Two addresses with the same index and different tags evict each other.
- R7: pred_hit is 1 only when lk_valid and lk_btb_hit are both 1 and the indexed entry is valid with a matching tag. On a hit, pred_target is the stored target. Otherwise pred_target is zero.
- R8: A write stores its tag and target at its hashed index and replaces the old entry. The hash uses the path value from before any retire update in the same cycle. The entry is visible to lookups from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_line | input | 15 | Lookup address bits [18:4] |
| lk_btb_hit | input | 1 | Main target buffer also hit |
| pred_hit | output | 1 | Prediction available |
| pred_target | output | TGT_W | Predicted target, zero on miss |
| rt_valid | input | 1 | Retired branch present |
| rt_kind | input | 3 | Branch kind code (0 cond, 1 indirect, 2 jump, 3 call, 4 return) |
| rt_taken | input | 1 | Retired branch outcome |
| rt_line | input | 15 | Retired branch address bits [18:4] |
| rt_tgt_lo | input | 6 | Retired branch target bits [5:0] |
| wr_valid | input | 1 | Target write request |
| wr_line | input | 15 | Write address bits [18:4] |
| wr_target | input | TGT_W | Resolved target to store |

## Verification
The bench builds the block with its default TGT_W of 32, and the table geometry is fixed by the hash bit positions. A full-width target shows that the whole stored value comes back on a hit. Random traffic drawn from a small address pool, with rare retires, makes write-then-lookup hits common, while path changes and index aliasing still occur. Directed cases cover the same-cycle write and retire. In that case a lookup address is solved so that its post-update hash equals the write's pre-update hash.

// File: rtl/itp_pkg.sv
package itp_pkg;

  localparam int PATH_W = 15;
  localparam int LINE_W = 15;
  localparam int IDX_W  = 8;
  localparam int TAG_W  = 7;
  localparam int TLO_W  = 6;

  localparam logic [2:0] KIND_COND = 3'd0;
  localparam logic [2:0] KIND_IND  = 3'd1;

  // Only taken conditionals and indirect branches move the path.
  function automatic logic path_moves(logic [2:0] kind, logic taken);
    return ((kind == KIND_COND) && taken) || (kind == KIND_IND);
  endfunction

  // line = address bits [18:4]; an indirect feeds addr[18:12] and target[5:0].
  function automatic logic [PATH_W-1:0] path_feed(logic [2:0] kind,
                                                  logic [LINE_W-1:0] line,
                                                  logic [TLO_W-1:0] tlo);
    if (kind == KIND_IND) return {line[14:8], tlo};
    return line;
  endfunction

  function automatic logic [PATH_W-1:0] path_advance(logic [PATH_W-1:0] p,
                                                     logic [PATH_W-1:0] feed);
    return {p[PATH_W-3:0], 2'b00} ^ feed;
  endfunction

  function automatic logic [PATH_W-1:0] mix_hash(logic [PATH_W-1:0] p,
                                                 logic [LINE_W-1:0] line);
    logic [PATH_W-1:0] h;
    h[14]   = line[8] ^ p[14];
    h[13:6] = line[7:0] ^ p[13:6];
    h[5:0]  = line[14:9] ^ p[5:0];
    return h;
  endfunction

  function automatic logic [IDX_W-1:0] hash_index(logic [PATH_W-1:0] h);
    return h[13:6];
  endfunction

  function automatic logic [TAG_W-1:0] hash_tag(logic [PATH_W-1:0] h);
    return {h[14], h[5:0]};
  endfunction

endpackage

// File: rtl/itp_path_hist.sv
module itp_path_hist
  import itp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rt_valid,
  input  logic [2:0]        rt_kind,
  input  logic              rt_taken,
  input  logic [LINE_W-1:0] rt_line,
  input  logic [TLO_W-1:0]  rt_tgt_lo,
  output logic [PATH_W-1:0] path_q,
  output logic              path_step
);

  logic [PATH_W-1:0] feed;

  assign path_step = rt_valid && path_moves(rt_kind, rt_taken);
  assign feed      = path_feed(rt_kind, rt_line, rt_tgt_lo);

  always_ff @(posedge clk) begin
    if (!rst_n)         path_q <= '0;
    else if (path_step) path_q <= path_advance(path_q, feed);
  end

endmodule

// File: rtl/itp_hash.sv
module itp_hash
  import itp_pkg::*;
(
  input  logic [PATH_W-1:0] path,
  input  logic [LINE_W-1:0] line,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);

  logic [PATH_W-1:0] h;

  assign h   = mix_hash(path, line);
  assign idx = hash_index(h);
  assign tag = hash_tag(h);

endmodule

// File: rtl/itp_target_store.sv
module itp_target_store #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 7,
  parameter int TGT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_match,
  output logic [TGT_W-1:0] rd_target,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [TGT_W-1:0] wr_target,
  output logic [(1<<IDX_W)-1:0] ent_valid
);

  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [TGT_W-1:0] tgt_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n)     ent_valid <= '0;
    else if (wr_en) ent_valid[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= wr_tag;
      tgt_mem[wr_idx] <= wr_target;
    end
  end

  assign rd_match  = ent_valid[rd_idx] && (tag_mem[rd_idx] == rd_tag);
  assign rd_target = tgt_mem[rd_idx];

endmodule

// File: rtl/itp_predictor.sv
module itp_predictor
  import itp_pkg::*;
#(
  parameter int TGT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [14:0]       lk_line,
  input  logic              lk_btb_hit,
  output logic              pred_hit,
  output logic [TGT_W-1:0]  pred_target,
  input  logic              rt_valid,
  input  logic [2:0]        rt_kind,
  input  logic              rt_taken,
  input  logic [14:0]       rt_line,
  input  logic [5:0]        rt_tgt_lo,
  input  logic              wr_valid,
  input  logic [14:0]       wr_line,
  input  logic [TGT_W-1:0]  wr_target
);

  localparam int DEPTH = 1 << IDX_W;

  logic [PATH_W-1:0] path_q;
  logic              path_step;
  logic [IDX_W-1:0]  lk_idx, wr_idx;
  logic [TAG_W-1:0]  lk_tag, wr_tag;
  logic              lk_match;
  logic [TGT_W-1:0]  lk_target;
  logic [DEPTH-1:0]  ent_valid;

  itp_path_hist u_path (
    .clk(clk), .rst_n(rst_n), .rt_valid(rt_valid), .rt_kind(rt_kind),
    .rt_taken(rt_taken), .rt_line(rt_line), .rt_tgt_lo(rt_tgt_lo),
    .path_q(path_q), .path_step(path_step)
  );

  // Both hashes see the registered path, i.e. the value before this cycle's retire.
  itp_hash u_lk_hash (.path(path_q), .line(lk_line), .idx(lk_idx), .tag(lk_tag));
  itp_hash u_wr_hash (.path(path_q), .line(wr_line), .idx(wr_idx), .tag(wr_tag));

  itp_target_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(TGT_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_idx), .rd_tag(lk_tag), .rd_match(lk_match), .rd_target(lk_target),
    .wr_en(wr_valid), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_target(wr_target),
    .ent_valid(ent_valid)
  );

  assign pred_hit    = lk_valid && lk_btb_hit && lk_match;
  assign pred_target = pred_hit ? lk_target : '0;

endmodule

// File: rtl/itp_checker.sv
module itp_checker (
  input logic         clk,
  input logic         rst_n,
  input logic         rt_valid,
  input logic [2:0]   rt_kind,
  input logic         rt_taken,
  input logic [14:0]  rt_line,
  input logic [5:0]   rt_tgt_lo,
  input logic [14:0]  path_q,
  input logic         lk_valid,
  input logic         lk_btb_hit,
  input logic         pred_hit,
  input logic         wr_valid,
  input logic [7:0]   wr_idx,
  input logic [255:0] ent_valid
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (path_q == 15'd0) && (ent_valid == '0));

  // R2
  cond_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rt_valid && rt_kind == 3'd0 && rt_taken
    |=> path_q == ({$past(path_q[12:0]), 2'b00} ^ $past(rt_line)));

  // R3
  ind_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rt_valid && rt_kind == 3'd1
    |=> path_q == ({$past(path_q[12:0]), 2'b00} ^ {$past(rt_line[14:8]), $past(rt_tgt_lo)}));

  // R4
  path_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_valid || (rt_kind == 3'd0 && !rt_taken) || rt_kind > 3'd1
    |=> $stable(path_q));

  // R7
  hit_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_hit |-> lk_valid && lk_btb_hit);

  // R8
  write_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> ent_valid[$past(wr_idx)]);

endmodule

bind itp_predictor itp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rt_valid(rt_valid), .rt_kind(rt_kind),
  .rt_taken(rt_taken), .rt_line(rt_line), .rt_tgt_lo(rt_tgt_lo),
  .path_q(path_q), .lk_valid(lk_valid), .lk_btb_hit(lk_btb_hit),
  .pred_hit(pred_hit), .wr_valid(wr_valid), .wr_idx(wr_idx),
  .ent_valid(ent_valid)
);

// File: tb/sim_itp_predictor.sv
module sim_itp_predictor;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_btb_hit = 1'b0;
  logic [14:0] lk_line = '0;
  logic        pred_hit;
  logic [31:0] pred_target;
  logic        rt_valid = 1'b0, rt_taken = 1'b0;
  logic [2:0]  rt_kind = '0;
  logic [14:0] rt_line = '0;
  logic [5:0]  rt_tgt_lo = '0;
  logic        wr_valid = 1'b0;
  logic [14:0] wr_line = '0;
  logic [31:0] wr_target = '0;

  int checks = 0, errors = 0;

  logic [14:0] m_path;
  logic        m_vld [256];
  logic [6:0]  m_tag [256];
  logic [31:0] m_tgt [256];
  logic [14:0] pool [8];

  always #4 clk = ~clk;

  itp_predictor #(.TGT_W(32)) u0 (.*);

  function automatic logic [14:0] b_hash(logic [14:0] p, logic [14:0] ln);
    logic [14:0] h;
    for (int k = 0; k < 15; k++) h[k] = 1'b0;
    h[14] = p[14] ^ ln[8];
    for (int k = 0; k < 8; k++) h[6+k] = p[6+k] ^ ln[k];
    for (int k = 0; k < 6; k++) h[k] = p[k] ^ ln[9+k];
    return h;
  endfunction

  function automatic logic [14:0] b_next(logic [14:0] p, logic [2:0] kind, logic tk,
                                         logic [14:0] ln, logic [5:0] tl);
    logic [14:0] sh;
    sh = p << 2;
    case (kind)
      3'd0: return tk ? (sh ^ ln) : p;
      3'd1: return sh ^ {ln[14:8], tl};
      default: return p;
    endcase
  endfunction

  // Line whose hash under path q equals the hash of line ln under path p.
  function automatic logic [14:0] b_remap(logic [14:0] ln, logic [14:0] p, logic [14:0] q);
    logic [14:0] d;
    d = p ^ q;
    return ln ^ {d[5:0], d[14], d[13:6]};
  endfunction

  task automatic model_reset();
    m_path = '0;
    for (int i = 0; i < 256; i++) m_vld[i] = 1'b0;
  endtask

  task automatic check_lookup(string req);
    logic [14:0] h;
    logic        eh;
    logic [31:0] et;
    h  = b_hash(m_path, lk_line);
    eh = lk_valid && lk_btb_hit && m_vld[h[13:6]] && (m_tag[h[13:6]] == {h[14], h[5:0]});
    et = eh ? m_tgt[h[13:6]] : 32'd0;
    checks++;
    if (pred_hit !== eh || pred_target !== et) begin
      errors++;
      $display("FAIL %s hit=%0b tgt=%h expected hit=%0b tgt=%h", req, pred_hit, pred_target, eh, et);
    end
  endtask

  task automatic expect_hit(string req, logic want);
    checks++;
    if (pred_hit !== want) begin
      errors++;
      $display("FAIL %s hit=%0b expected %0b", req, pred_hit, want);
    end
  endtask

  // Drive one cycle at negedge, check lookup, then advance the model at posedge.
  task automatic step(logic lv, logic [14:0] la, logic lb,
                      logic rv, logic [2:0] rk, logic rtk, logic [14:0] ra, logic [5:0] rtl,
                      logic wv, logic [14:0] wa, logic [31:0] wt, string req);
    logic [14:0] h;
    @(negedge clk);
    lk_valid = lv; lk_line = la; lk_btb_hit = lb;
    rt_valid = rv; rt_kind = rk; rt_taken = rtk; rt_line = ra; rt_tgt_lo = rtl;
    wr_valid = wv; wr_line = wa; wr_target = wt;
    #1;
    if (lv) check_lookup(req);
    @(posedge clk);
    if (wv) begin
      h = b_hash(m_path, wa);
      m_vld[h[13:6]] = 1'b1;
      m_tag[h[13:6]] = {h[14], h[5:0]};
      m_tgt[h[13:6]] = wt;
    end
    if (rv) m_path = b_next(m_path, rk, rtk, ra, rtl);
  endtask

  task automatic look(logic [14:0] la, logic lb, string req);
    step(1'b1, la, lb, 1'b0, 3'd0, 1'b0, '0, '0, 1'b0, '0, '0, req);
  endtask

  task automatic retire(logic [2:0] rk, logic tk, logic [14:0] ra, logic [5:0] tl);
    step(1'b0, '0, 1'b0, 1'b1, rk, tk, ra, tl, 1'b0, '0, '0, "none");
  endtask

  task automatic write(logic [14:0] wa, logic [31:0] wt);
    step(1'b0, '0, 1'b0, 1'b0, 3'd0, 1'b0, '0, '0, 1'b1, wa, wt, "none");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [14:0] a, b, old_p, a2;
    void'($urandom(32'h1d5c_7a03));
    model_reset();
    for (int i = 0; i < 8; i++) pool[i] = 15'($urandom);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    a = 15'h2a5c;
    // R1: nothing hits straight after reset
    look(a, 1'b1, "R1");
    expect_hit("R1", 1'b0);

    // R8/R5: write then read back
    write(a, 32'hcafe_0001);
    look(a, 1'b1, "R8");
    @(negedge clk); lk_valid = 1'b1; lk_line = a; lk_btb_hit = 1'b1; #1;
    expect_hit("R8", 1'b1);
    // R7: no hit without the main buffer qualifier
    look(a, 1'b0, "R7");
    @(negedge clk); lk_valid = 1'b1; lk_line = a; lk_btb_hit = 1'b0; #1;
    expect_hit("R7", 1'b0);

    // R4: non-updating retires keep the entry reachable
    retire(3'd0, 1'b0, 15'h7fff, 6'h3f);
    look(a, 1'b1, "R4 not-taken cond");
    retire(3'd2, 1'b1, 15'h1234, 6'h11);
    retire(3'd3, 1'b1, 15'h4321, 6'h22);
    retire(3'd4, 1'b1, 15'h0f0f, 6'h33);
    retire(3'd7, 1'b1, 15'h5555, 6'h2a);
    look(a, 1'b1, "R4 jump/call/ret");
    @(negedge clk); lk_valid = 1'b1; lk_line = a; lk_btb_hit = 1'b1; #1;
    expect_hit("R4", 1'b1);

    // R2: taken conditional moves the path
    retire(3'd0, 1'b1, 15'h0101, 6'h00);
    look(a, 1'b1, "R2");
    write(a, 32'hbeef_0002);
    look(a, 1'b1, "R2 refill");
    // R3: indirect branch moves the path, taken flag ignored
    retire(3'd1, 1'b0, 15'h3300, 6'h15);
    look(a, 1'b1, "R3");
    write(a, 32'h1357_9bdf);
    look(a, 1'b1, "R3 refill");

    // R6: same index, different tag (flip address bit 13 -> line bit 9)
    b = a ^ 15'h0200;
    write(b, 32'h2468_ace0);
    look(a, 1'b1, "R6 evicted");
    @(negedge clk); lk_valid = 1'b1; lk_line = a; lk_btb_hit = 1'b1; #1;
    expect_hit("R6", 1'b0);
    look(b, 1'b1, "R6 new owner");

    // R8: same-cycle write and retire hash with the old path
    old_p = m_path;
    step(1'b0, '0, 1'b0, 1'b1, 3'd0, 1'b1, 15'h6a1c, 6'h0, 1'b1, a, 32'h0bad_f00d, "none");
    a2 = b_remap(a, old_p, m_path);
    look(a2, 1'b1, "R8 same-cycle");
    @(negedge clk); lk_valid = 1'b1; lk_line = a2; lk_btb_hit = 1'b1; #1;
    expect_hit("R8 same-cycle", 1'b1);

    // Random traffic: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 3000; i++) begin
      logic rv, wv, lb;
      rv = ($urandom % 8) == 0;
      wv = ($urandom % 3) == 0;
      lb = ($urandom % 6) != 0;
      step(1'b1, pool[$urandom % 8], lb,
           rv, 3'($urandom), 1'($urandom), pool[$urandom % 8], 6'($urandom),
           wv, pool[$urandom % 8], $urandom, "R5/R6/R7 random");
    end

    // R1: reset again clears path and entries
    @(negedge clk); rst_n = 1'b0; lk_valid = 1'b0; rt_valid = 1'b0; wr_valid = 1'b0;
    repeat (2) @(posedge clk);
    model_reset();
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < 8; i++) look(pool[i], 1'b1, "R1 after re-reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule